// File: doc/BRIEF.md
# Tagged Receive Character Queue

This block is the receive-side character buffer of one serial channel. A deserializer hands it one character per cycle, together with three status bits describing that character: a parity error, a framing error and a detected line break. Characters and their status bits are stored together, so the status always belongs to the character it arrived with. A register-read path drains the queue. The character at the head, and its status bits, are always visible on the read outputs.

The fill level is compared with one of four selectable thresholds to raise a data-available interrupt request. An active-low ready output lets an external DMA engine see that receive data is waiting. It works in two modes: a per-character mode and a burst mode that stays asserted until the queue drains. Characters pushed into a full queue are dropped and recorded in a sticky overrun flag. A clear input empties the queue in one cycle and leaves the rest of the channel untouched.

Top module: `uart_rxq`

## Requirements
- R1: The queue holds 16 characters. `level` reports the number stored. A push is accepted when fewer than 16 are stored, or when a read is taken in the same cycle.
- R2: Characters leave in arrival order. `rd_data`, `rd_perr`, `rd_ferr` and `rd_brk` show the head character and its own status bits. All four read as zero while the queue is empty.
- R3: The `char_len` code gives the character length: 00 is 5 bits, 01 is 6, 10 is 7 and 11 is 8. Data bits above that length are cleared when the character is stored, so they read back as zero.
- R4: The `trig_sel` code gives the threshold: 00 is 1 character, 01 is 4, 10 is 8 and 11 is 14. `data_irq` is high in exactly the cycles in which `level` is at or above the threshold.
- R5: A push into a full queue with no read in that cycle is dropped and sets `overrun` from the next cycle. A `lsr_read` pulse clears `overrun`. If a drop and a clear fall in the same cycle, the flag stays set.
- R6: With `dma_block` low, `rx_rdy_n` is low exactly while `level` is nonzero.
- R7: With `dma_block` high, `rx_rdy_n` goes low when `level` reaches the threshold. It also goes low one cycle after a `timeout` pulse that arrives while `level` is nonzero. It then stays low until `level` reads zero. Any cycle with `level` at zero cancels the low state.
- R8: A `fifo_clr` pulse gives a `level` of zero on the next cycle and clears the stored status bits. It takes priority over a push or a read in the same cycle. It does not change `overrun`.
- R9: A read while the queue is empty is ignored. A push and a read in the same cycle on a non-empty queue leave `level` unchanged and advance the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push | input | 1 | Deserializer delivers a character |
| push_data | input | 8 | Received character bits |
| push_perr | input | 1 | Parity error for this character |
| push_ferr | input | 1 | Framing error for this character |
| push_brk | input | 1 | Break detected with this character |
| char_len | input | 2 | Character length code |
| pop | input | 1 | Read strobe, removes the head character |
| lsr_read | input | 1 | Line-status read, clears overrun |
| fifo_clr | input | 1 | Empties the queue |
| trig_sel | input | 2 | Threshold code |
| dma_block | input | 1 | 0 per-character ready, 1 burst ready |
| timeout | input | 1 | Character-timeout pulse |
| rd_data | output | 8 | Head character |
| rd_perr | output | 1 | Head parity error |
| rd_ferr | output | 1 | Head framing error |
| rd_brk | output | 1 | Head break indication |
| level | output | 5 | Number of stored characters |
| data_irq | output | 1 | Data-available interrupt request |
| rx_rdy_n | output | 1 | Active-low receive-ready for DMA |
| overrun | output | 1 | Sticky overrun flag |

## Verification
A push and a read can land in the same cycle. That case matters most at the two edges of the queue: when it is full, the read makes room and no overrun may appear; when it is empty, the read must be ignored and the push kept. The bench provokes it with directed fills to 16 and drains to zero, and then with random traffic biased toward both pulses at once. The same approach covers an overrun drop coinciding with a status read. Every cycle the bench judges `level`, the head and the flags against a reference queue held in the bench.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam int unsigned CHAR_W = 8;

  typedef struct packed {
    logic brk;
    logic ferr;
    logic perr;
  } rxq_tag_t;

  // Keep only the low 5..8 bits of a character.
  function automatic logic [CHAR_W-1:0] len_mask(input logic [1:0] code);
    return {CHAR_W{1'b1}} >> (2'd3 - code);
  endfunction

  // Threshold for each selection code.
  function automatic int unsigned trig_level(input logic [1:0] code);
    case (code)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [CHAR_W-1:0] wr_data,
  input  rxq_tag_t          wr_tag,
  input  logic              rd_en,
  output logic [CHAR_W-1:0] head_data,
  output rxq_tag_t          head_tag,
  output logic [CW-1:0]     cnt
);

  logic [CHAR_W-1:0] data_mem [DEPTH];
  rxq_tag_t          tag_mem  [DEPTH];
  logic [AW-1:0]     wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0]     cnt_q, cnt_d;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (clr) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (wr_en) wptr_d = ptr_inc(wptr_q);
      if (rd_en) rptr_d = ptr_inc(rptr_q);
      if (wr_en && !rd_en)      cnt_d = cnt_q + 1'b1;
      else if (rd_en && !wr_en) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        data_mem[i] <= '0;
        tag_mem[i]  <= '0;
      end
    end else if (clr) begin
      for (int i = 0; i < DEPTH; i++) tag_mem[i] <= '0;
    end else if (wr_en) begin
      data_mem[wptr_q] <= wr_data;
      tag_mem[wptr_q]  <= wr_tag;
    end
  end

  assign cnt       = cnt_q;
  assign head_data = (cnt_q == '0) ? '0 : data_mem[rptr_q];
  assign head_tag  = (cnt_q == '0) ? '0 : tag_mem[rptr_q];

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R1
  push_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && !clr) |=> cnt_q == $past(cnt_q) + CW'(1));

  // R8
  clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0);

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          clr,
  input  logic          lsr_read,
  input  logic [CW-1:0] cnt,
  output logic          wr_en,
  output logic          rd_en,
  output logic          overrun
);

  logic full, empty, drop;
  logic ovr_q, ovr_d;

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign rd_en = pop && !empty && !clr;
  assign wr_en = push && !clr && (!full || rd_en);
  assign drop  = push && !clr && full && !rd_en;

  always_comb begin
    ovr_d = ovr_q;
    if (drop)          ovr_d = 1'b1;
    else if (lsr_read) ovr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= ovr_d;
  end

  assign overrun = ovr_q;

  // R5
  ovr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> ($past(push) && $past(cnt) == CW'(DEPTH)));

  // R5
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !lsr_read) |=> $stable(ovr_q));

endmodule

// File: rtl/rxq_ready.sv
module rxq_ready
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic [1:0]    trig_sel,
  input  logic          block_mode,
  input  logic          timeout,
  output logic          data_irq,
  output logic          rx_rdy_n
);

  logic          hit, nonempty;
  logic          armed_q, armed_d;
  logic [CW-1:0] thresh;

  assign thresh   = CW'(trig_level(trig_sel));
  assign hit      = (cnt >= thresh);
  assign nonempty = (cnt != '0);
  assign data_irq = hit;

  always_comb begin
    armed_d = nonempty && (armed_q || hit || timeout);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  always_comb begin
    if (block_mode) rx_rdy_n = !(nonempty && (armed_q || hit));
    else            rx_rdy_n = !nonempty;
  end

  // R6
  rdy_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> rx_rdy_n);

  // R4
  irq_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_irq |-> nonempty);

endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [7:0]    push_data,
  input  logic          push_perr,
  input  logic          push_ferr,
  input  logic          push_brk,
  input  logic [1:0]    char_len,
  input  logic          pop,
  input  logic          lsr_read,
  input  logic          fifo_clr,
  input  logic [1:0]    trig_sel,
  input  logic          dma_block,
  input  logic          timeout,
  output logic [7:0]    rd_data,
  output logic          rd_perr,
  output logic          rd_ferr,
  output logic          rd_brk,
  output logic [CW-1:0] level,
  output logic          data_irq,
  output logic          rx_rdy_n,
  output logic          overrun
);

  logic [1:0]    rst_sync_q;
  logic          srst_n;
  logic          wr_en, rd_en;
  logic [CW-1:0] cnt;
  rxq_tag_t      in_tag, hd_tag;
  logic [7:0]    in_data;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  assign in_data = push_data & len_mask(char_len);
  assign in_tag  = '{brk: push_brk, ferr: push_ferr, perr: push_perr};

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(srst_n), .push(push), .pop(pop), .clr(fifo_clr),
    .lsr_read(lsr_read), .cnt(cnt), .wr_en(wr_en), .rd_en(rd_en),
    .overrun(overrun)
  );

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(srst_n), .clr(fifo_clr), .wr_en(wr_en),
    .wr_data(in_data), .wr_tag(in_tag), .rd_en(rd_en),
    .head_data(rd_data), .head_tag(hd_tag), .cnt(cnt)
  );

  rxq_ready #(.DEPTH(DEPTH)) u_ready (
    .clk(clk), .rst_n(srst_n), .cnt(cnt), .trig_sel(trig_sel),
    .block_mode(dma_block), .timeout(timeout), .data_irq(data_irq),
    .rx_rdy_n(rx_rdy_n)
  );

  assign level   = cnt;
  assign rd_perr = hd_tag.perr;
  assign rd_ferr = hd_tag.ferr;
  assign rd_brk  = hd_tag.brk;

endmodule

// File: tb/uart_rxq_test.sv
module uart_rxq_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       push, pop, lsr_read, fifo_clr, dma_block, timeout;
  logic       push_perr, push_ferr, push_brk;
  logic [7:0] push_data;
  logic [1:0] char_len, trig_sel;
  logic [7:0] rd_data;
  logic       rd_perr, rd_ferr, rd_brk, data_irq, rx_rdy_n, overrun;
  logic [4:0] level;

  int checks = 0;
  int errors = 0;

  // Reference model state
  logic [10:0] mq[$];
  bit          m_ovr;
  bit          m_arm;

  always #4 clk = ~clk;

  uart_rxq uut (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
    .push_perr(push_perr), .push_ferr(push_ferr), .push_brk(push_brk),
    .char_len(char_len), .pop(pop), .lsr_read(lsr_read),
    .fifo_clr(fifo_clr), .trig_sel(trig_sel), .dma_block(dma_block),
    .timeout(timeout), .rd_data(rd_data), .rd_perr(rd_perr),
    .rd_ferr(rd_ferr), .rd_brk(rd_brk), .level(level),
    .data_irq(data_irq), .rx_rdy_n(rx_rdy_n), .overrun(overrun)
  );

  function automatic int thr(input logic [1:0] c);
    int t[4] = '{1, 4, 8, 14};
    return t[c];
  endfunction

  function automatic logic [7:0] keep_bits(input logic [7:0] d, input logic [1:0] l);
    return d & 8'((1 << (5 + int'(l))) - 1);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    int sz = mq.size();
    logic [10:0] hd = (sz != 0) ? mq[0] : 11'd0;
    bit rdy;
    chk("R1", "level", int'(level), sz);
    chk("R2", "head data", int'(rd_data), int'(hd[7:0]));
    chk("R2", "head tags", int'({rd_brk, rd_ferr, rd_perr}), int'(hd[10:8]));
    chk("R4", "data_irq", int'(data_irq), int'(sz >= thr(trig_sel)));
    chk("R5", "overrun", int'(overrun), int'(m_ovr));
    if (dma_block) begin
      rdy = (sz != 0) && (m_arm || sz >= thr(trig_sel));
      chk("R7", "rx_rdy_n", int'(rx_rdy_n), int'(!rdy));
    end else begin
      chk("R6", "rx_rdy_n", int'(rx_rdy_n), int'(sz == 0));
    end
  endtask

  // Update the model with the inputs that were present at the edge.
  task automatic model_edge();
    int  sz   = mq.size();
    bit  rd   = pop && sz != 0 && !fifo_clr;
    bit  full = (sz == 16);
    bit  wr   = push && !fifo_clr && (!full || rd);
    bit  drop = push && !fifo_clr && full && !rd;
    m_arm = (sz != 0) && (m_arm || sz >= thr(trig_sel) || timeout);
    if (fifo_clr) mq.delete();
    else begin
      if (rd) void'(mq.pop_front());
      if (wr) mq.push_back({push_brk, push_ferr, push_perr, keep_bits(push_data, char_len)});
    end
    if (drop) m_ovr = 1'b1;
    else if (lsr_read) m_ovr = 1'b0;
  endtask

  task automatic idle();
    push = 0; pop = 0; lsr_read = 0; fifo_clr = 0; timeout = 0;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_all();
  endtask

  task automatic do_push(input logic [7:0] d, input logic [2:0] t);
    idle();
    push = 1; push_data = d; {push_brk, push_ferr, push_perr} = t;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements: actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    idle();
    push_data = 0; push_perr = 0; push_ferr = 0; push_brk = 0;
    char_len = 2'b11; trig_sel = 2'b00; dma_block = 0;
    m_ovr = 0; m_arm = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1", "reset level", int'(level), 0);
    chk("R6", "reset rx_rdy_n", int'(rx_rdy_n), 1);
    chk("R4", "reset data_irq", int'(data_irq), 0);
    chk("R5", "reset overrun", int'(overrun), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R3: length masking for each code
    for (int l = 0; l < 4; l++) begin
      char_len = 2'(l);
      do_push(8'hFF, 3'b000);
    end
    char_len = 2'b11;
    for (int l = 0; l < 4; l++) begin
      chk("R3", "masked data", int'(rd_data), (1 << (5 + l)) - 1);
      idle(); pop = 1; step();
    end

    // R9: pop when empty is ignored
    idle(); pop = 1; step();
    chk("R9", "pop on empty", int'(level), 0);

    // R1/R5: fill, then overflow; R9 push+pop at full
    trig_sel = 2'b11;
    for (int i = 0; i < 16; i++) do_push(8'(i + 8'h30), 3'(i));
    do_push(8'hEE, 3'b111);
    chk("R5", "overrun after drop", int'(overrun), 1);
    idle(); push = 1; pop = 1; push_data = 8'h99; step();
    chk("R9", "push+pop at full keeps level", int'(level), 16);
    idle(); lsr_read = 1; push = 1; step();
    chk("R5", "drop wins over clear", int'(overrun), 1);
    idle(); lsr_read = 1; step();
    chk("R5", "clear by status read", int'(overrun), 0);

    // R8: clear has priority over push and pop
    idle(); fifo_clr = 1; push = 1; pop = 1; step();
    chk("R8", "level after clear", int'(level), 0);
    chk("R8", "tags after clear", int'({rd_brk, rd_ferr, rd_perr}), 0);

    // R4 sweep thresholds while filling
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      idle(); fifo_clr = 1; step();
      for (int i = 0; i < 15; i++) do_push(8'(i), 3'b010);
    end

    // R7: block mode with timeout and drain
    dma_block = 1; trig_sel = 2'b10;
    idle(); fifo_clr = 1; step();
    do_push(8'h11, 3'b001);
    do_push(8'h22, 3'b100);
    idle(); timeout = 1; step();
    idle(); step();
    chk("R7", "armed by timeout", int'(rx_rdy_n), 0);
    idle(); pop = 1; step(); step();
    chk("R7", "released when empty", int'(rx_rdy_n), 1);

    // Random traffic
    for (int n = 0; n < 6000; n++) begin
      idle();
      push      = ($urandom_range(99) < 55);
      pop       = ($urandom_range(99) < 45);
      lsr_read  = ($urandom_range(99) < 5);
      fifo_clr  = ($urandom_range(999) < 8);
      timeout   = ($urandom_range(99) < 4);
      push_data = 8'($urandom);
      {push_brk, push_ferr, push_perr} = 3'($urandom);
      if ($urandom_range(99) < 3) char_len  = 2'($urandom);
      if ($urandom_range(99) < 2) trig_sel  = 2'($urandom);
      if ($urandom_range(99) < 2) dma_block = 1'($urandom);
      step();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule